// File: doc/BRIEF.md
# IDE Configuration Register Window

This block is a slave on an IDE-style task-file register bus with byte and word accesses. Normally the low register offsets reach a set of plain storage registers standing in for the task file. The block also watches every access for a short unlock pattern: two consecutive word reads of offset 1 followed by a byte write of 0x03 to offset 2. Once that pattern completes, the same offsets reach a hidden bank of controller settings instead. These are per-drive read and write cycle timing, a control byte, a read-only bus-speed strap and a miscellaneous byte. A byte write of 0x83 to offset 2 returns the bus to the task file.

The timing and miscellaneous settings leave the block on dedicated configuration outputs, for the cycle-timing logic that uses them. Read data is combinational in the cycle the read strobe is high. Writes take effect at the next clock edge.

Top module: `ide_cfg_window`

## Requirements
- R1: A synchronous active-high reset closes the window and clears the unlock progress. It clears the task-file registers, both drives' timing bytes and the misc byte, and loads the control byte with 0x11. While reset is high the strap input is captured.
- R2: With the window closed, a word write (`bus_word`=1) stores all 16 bits of the task-file register at `bus_addr`. A byte write stores bits 7:0 and keeps bits 15:8. A word read returns the whole register. A byte read returns bits 7:0 with zero upper bits. `bus_rdata` is 0 whenever `bus_rd` is low.
- R3: Two word reads of offset 1, with no other access between them, followed directly by a byte write of 0x03 to offset 2, open the window at the next edge. The reads return the task-file register 1 contents. That write also stores 0x03 into the low byte of task-file register 2. Further qualifying reads before the key write keep the window armable.
- R4: Any other access before the key write restarts the unlock progress and leaves the window closed. This includes a read at another offset, a byte read of offset 1, a word write, or a key byte other than 0x03.
- R5: While open, only a byte write whose bits 7:0 equal 0x83 to offset 2 closes the window. A word write or any other byte value at offset 2 leaves it open.
- R6: While open, hidden offset 0 is the read-cycle timing byte and offset 1 is the write-cycle timing byte. In each, bits 3:0 are recovery and bits 7:4 are pulse width. One copy is kept per drive, and misc bit 0 selects which copy is accessed.
- R7: While open, hidden offset 3 is a fully writable control byte. 0x95 means enabled and 0x11 means disabled.
- R8: While open, hidden offset 5 reads the strap: bit 0 is the captured strap pin (0 for 33 MHz, 1 for 25 MHz) and the other bits are 0. Writes to it have no effect.
- R9: While open, hidden offset 6 is the misc byte. Bit 0 is the drive select, bits 3:1 a delay, bits 5:4 address setup and bit 6 read prefetch. Bit 7 is not writable and reads 0.
- R10: While open, hidden offsets 2, 4 and 7 read 0. No hidden-bank write changes any task-file register.
- R11: `cfg_ctrl`, `cfg_misc`, `cfg_rd_tim` and `cfg_wr_tim` show the stored settings, drive n in bits 8n+7:8n, from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_in | input | 1 | Bus-speed strap, captured during reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high |
| win_open | output | 1 | Hidden bank is mapped |
| cfg_ctrl | output | 8 | Control byte |
| cfg_misc | output | 8 | Misc byte |
| cfg_rd_tim | output | NUM_DRIVES*8 | Read-cycle timing per drive |
| cfg_wr_tim | output | NUM_DRIVES*8 | Write-cycle timing per drive |

## Verification
A wrong unlock count or window state shows up in the first read after the key write. That read returns task-file contents where a hidden byte was due, or the reverse. `win_open` makes this visible one edge after the faulty access. A wrong drive select or a lost write shows on the configuration outputs one edge after the write, well before it is read back. Bench checks compare every cycle against a behavioural model, so a divergence is caught in the cycle it appears.

// File: rtl/icw_pkg.sv
package icw_pkg;
   typedef enum logic {WIN_CLOSED = 1'b0, WIN_OPEN = 1'b1} icw_win_e;

   localparam int HID_RD_TIM = 0;
   localparam int HID_WR_TIM = 1;
   localparam int HID_CTRL   = 3;
   localparam int HID_STRAP  = 5;
   localparam int HID_MISC   = 6;
endpackage

// File: rtl/icw_unlock_fsm.sv
module icw_unlock_fsm
   import icw_pkg::*;
#(
   parameter int          ADDR_W    = 3,
   parameter int          SEQ_OFF   = 1,
   parameter int          KEY_OFF   = 2,
   parameter int          SEQ_READS = 2,
   parameter logic [7:0]  OPEN_KEY  = 8'h03,
   parameter logic [7:0]  CLOSE_KEY = 8'h83
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              word,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        key_byte,
   output logic              open
);
   localparam int CNT_W = $clog2(SEQ_READS + 1);

   if (SEQ_READS < 1) begin : g_bad_reads
      $error("SEQ_READS must be at least 1");
   end

   icw_win_e         win_q;
   logic [CNT_W-1:0] cnt_q;
   logic             seq_rd, key_wr, armed;

   assign seq_rd = rd_en && !wr_en && word && (addr == ADDR_W'(SEQ_OFF));
   assign key_wr = wr_en && !word && (addr == ADDR_W'(KEY_OFF));
   assign armed  = (cnt_q == CNT_W'(SEQ_READS));

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q <= WIN_CLOSED;
         cnt_q <= '0;
      end else if (win_q == WIN_OPEN) begin
         if (key_wr && key_byte == CLOSE_KEY) win_q <= WIN_CLOSED;
      end else if (wr_en) begin
         cnt_q <= '0;
         if (key_wr && key_byte == OPEN_KEY && armed) win_q <= WIN_OPEN;
      end else if (rd_en) begin
         if (!seq_rd)     cnt_q <= '0;
         else if (!armed) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign open = (win_q == WIN_OPEN);
endmodule

// File: rtl/icw_taskfile.sv
module icw_taskfile #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic              word,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int NREG  = 1 << ADDR_W;
   localparam int NLANE = DATA_W / 8;

   logic [NREG-1:0][DATA_W-1:0] regs;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      for (genvar l = 0; l < NLANE; l++) begin : g_lane
         logic [7:0] lane_q;
         always_ff @(posedge clk) begin
            if (rst)
               lane_q <= '0;
            else if (we && addr == ADDR_W'(r) && (word || l == 0))
               lane_q <= wdata[l*8 +: 8];
         end
         assign regs[r][l*8 +: 8] = lane_q;
      end
   end

   assign rdata = word ? regs[addr] : {{(DATA_W-8){1'b0}}, regs[addr][7:0]};
endmodule

// File: rtl/icw_cfg_bank.sv
module icw_cfg_bank
   import icw_pkg::*;
#(
   parameter int         ADDR_W     = 3,
   parameter int         NUM_DRIVES = 2,
   parameter logic [7:0] CTRL_RST   = 8'h11,
   parameter logic [7:0] MISC_WMASK = 8'h7F
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    strap_in,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [7:0]              wbyte,
   output logic [7:0]              rbyte,
   output logic [7:0]              ctrl,
   output logic [7:0]              misc,
   output logic [NUM_DRIVES*8-1:0] rd_tim,
   output logic [NUM_DRIVES*8-1:0] wr_tim
);
   logic       strap_q;
   logic       sel;
   logic [7:0] ctrl_q, misc_q;

   if (NUM_DRIVES == 2) begin : g_two
      assign sel = misc_q[0];
   end else begin : g_one
      assign sel = 1'b0;
   end

   for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
      logic [7:0] rt_q, wt_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            rt_q <= '0;
            wt_q <= '0;
         end else if (we && sel == 1'(d)) begin
            if (addr == ADDR_W'(HID_RD_TIM)) rt_q <= wbyte;
            if (addr == ADDR_W'(HID_WR_TIM)) wt_q <= wbyte;
         end
      end
      assign rd_tim[d*8 +: 8] = rt_q;
      assign wr_tim[d*8 +: 8] = wt_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         strap_q <= strap_in;
         ctrl_q  <= CTRL_RST;
         misc_q  <= '0;
      end else if (we) begin
         if (addr == ADDR_W'(HID_CTRL)) ctrl_q <= wbyte;
         if (addr == ADDR_W'(HID_MISC)) misc_q <= wbyte & MISC_WMASK;
      end
   end

   always_comb begin
      rbyte = '0;
      case (addr)
         ADDR_W'(HID_RD_TIM): rbyte = rd_tim[sel*8 +: 8];
         ADDR_W'(HID_WR_TIM): rbyte = wr_tim[sel*8 +: 8];
         ADDR_W'(HID_CTRL):   rbyte = ctrl_q;
         ADDR_W'(HID_STRAP):  rbyte = {7'd0, strap_q};
         ADDR_W'(HID_MISC):   rbyte = misc_q;
         default:             rbyte = '0;
      endcase
   end

   assign ctrl = ctrl_q;
   assign misc = misc_q;
endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window #(
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 16,
   parameter int NUM_DRIVES = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    strap_in,
   input  logic                    bus_rd,
   input  logic                    bus_wr,
   input  logic                    bus_word,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic                    win_open,
   output logic [7:0]              cfg_ctrl,
   output logic [7:0]              cfg_misc,
   output logic [NUM_DRIVES*8-1:0] cfg_rd_tim,
   output logic [NUM_DRIVES*8-1:0] cfg_wr_tim
);
   if (DATA_W < 16 || DATA_W % 8 != 0) begin : g_bad_w
      $error("DATA_W must be a multiple of 8, at least 16");
   end
   if (ADDR_W < 3) begin : g_bad_a
      $error("ADDR_W must be at least 3");
   end
   if (NUM_DRIVES < 1 || NUM_DRIVES > 2) begin : g_bad_d
      $error("NUM_DRIVES must be 1 or 2");
   end

   logic              open;
   logic [DATA_W-1:0] tf_rdata;
   logic [7:0]        hid_rbyte;

   icw_unlock_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk(clk), .rst(rst), .rd_en(bus_rd), .wr_en(bus_wr), .word(bus_word),
      .addr(bus_addr), .key_byte(bus_wdata[7:0]), .open(open)
   );

   icw_taskfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tf (
      .clk(clk), .rst(rst), .we(bus_wr && !open), .word(bus_word),
      .addr(bus_addr), .wdata(bus_wdata), .rdata(tf_rdata)
   );

   icw_cfg_bank #(.ADDR_W(ADDR_W), .NUM_DRIVES(NUM_DRIVES)) u_bank (
      .clk(clk), .rst(rst), .strap_in(strap_in), .we(bus_wr && open),
      .addr(bus_addr), .wbyte(bus_wdata[7:0]), .rbyte(hid_rbyte),
      .ctrl(cfg_ctrl), .misc(cfg_misc), .rd_tim(cfg_rd_tim), .wr_tim(cfg_wr_tim)
   );

   always_comb begin
      if (!bus_rd)   bus_rdata = '0;
      else if (open) bus_rdata = {{(DATA_W-8){1'b0}}, hid_rbyte};
      else           bus_rdata = tf_rdata;
   end

   assign win_open = open;
endmodule

// File: rtl/ide_cfg_window_chk.sv
module ide_cfg_window_chk #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              bus_word,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              win_open,
   input logic [7:0]        cfg_ctrl
);
   logic rst_seen_q = 1'b0;
   always @(posedge clk) rst_seen_q <= rst;

   // R1: first cycle out of reset
   always @(negedge clk)
      if (rst_seen_q && !rst)
         assert_reset_state_R1: assert (!win_open && cfg_ctrl == 8'h11);

   assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |-> bus_rdata == '0);

   assert_open_by_key_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(win_open) |-> $past(bus_wr && !bus_word && bus_addr == ADDR_W'(2)
                                && bus_wdata[7:0] == 8'h03));

   assert_close_by_key_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(win_open) |-> $past(bus_wr && !bus_word && bus_addr == ADDR_W'(2)
                                && bus_wdata[7:0] == 8'h83));

   assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !(win_open && bus_wr && bus_addr == ADDR_W'(3)) |=> $stable(cfg_ctrl));

   assert_strap_bits_R8: assert property (@(posedge clk) disable iff (rst)
      (win_open && bus_rd && bus_addr == ADDR_W'(5)) |-> bus_rdata[DATA_W-1:1] == '0);

   assert_misc_top_R9: assert property (@(posedge clk) disable iff (rst)
      (win_open && bus_rd && bus_addr == ADDR_W'(6)) |-> bus_rdata[DATA_W-1:7] == '0);
endmodule

bind ide_cfg_window ide_cfg_window_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .win_open(win_open), .cfg_ctrl(cfg_ctrl)
);

// File: tb/ide_cfg_window_bench.sv
`timescale 1ns/1ps
module ide_cfg_window_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        strap_in = 1'b1;
   logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        win_open;
   logic [7:0]  cfg_ctrl, cfg_misc;
   logic [15:0] cfg_rd_tim, cfg_wr_tim;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ide_cfg_window u_ide_cfg_window (
      .clk(clk), .rst(rst), .strap_in(strap_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .win_open(win_open), .cfg_ctrl(cfg_ctrl),
      .cfg_misc(cfg_misc), .cfg_rd_tim(cfg_rd_tim), .cfg_wr_tim(cfg_wr_tim)
   );

   // behavioural reference model
   logic [15:0] m_tf [8];
   logic [7:0]  m_rt [2];
   logic [7:0]  m_wt [2];
   logic [7:0]  m_ctrl, m_misc;
   logic        m_strap, m_open;
   int          m_reads;

   function automatic logic [15:0] m_read(logic rd, logic wd, logic [2:0] a);
      logic [7:0] b;
      if (!rd) return 16'h0;
      if (!m_open) return wd ? m_tf[a] : {8'h0, m_tf[a][7:0]};
      case (a)
         3'd0: b = m_rt[m_misc[0]];
         3'd1: b = m_wt[m_misc[0]];
         3'd3: b = m_ctrl;
         3'd5: b = {7'd0, m_strap};
         3'd6: b = m_misc;
         default: b = 8'h0;
      endcase
      return {8'h0, b};
   endfunction

   task automatic m_reset(logic s);
      for (int i = 0; i < 8; i++) m_tf[i] = '0;
      for (int i = 0; i < 2; i++) begin m_rt[i] = '0; m_wt[i] = '0; end
      m_ctrl = 8'h11; m_misc = '0; m_strap = s; m_open = 0; m_reads = 0;
   endtask

   task automatic m_step(logic rd, logic wr, logic wd, logic [2:0] a, logic [15:0] d);
      if (m_open) begin
         if (wr) begin
            if (!wd && a == 3'd2 && d[7:0] == 8'h83) m_open = 0;
            else case (a)
               3'd0: m_rt[m_misc[0]] = d[7:0];
               3'd1: m_wt[m_misc[0]] = d[7:0];
               3'd3: m_ctrl = d[7:0];
               3'd6: m_misc = d[7:0] & 8'h7F;
               default: ;
            endcase
         end
      end else if (wr) begin
         if (wd) m_tf[a] = d; else m_tf[a][7:0] = d[7:0];
         if (!wd && a == 3'd2 && d[7:0] == 8'h03 && m_reads == 2) m_open = 1;
         m_reads = 0;
      end else if (rd) begin
         if (wd && a == 3'd1) m_reads = (m_reads < 2) ? m_reads + 1 : 2;
         else m_reads = 0;
      end
   endtask

   task automatic cyc(logic rd, logic wr, logic wd, logic [2:0] a, logic [15:0] d, string tag);
      logic [15:0] e_rd;
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_word = wd; bus_addr = a; bus_wdata = d;
      #1;
      e_rd = m_read(rd, wd, a);
      n_chk++;
      if (bus_rdata !== e_rd || win_open !== m_open || cfg_ctrl !== m_ctrl ||
          cfg_misc !== m_misc || cfg_rd_tim !== {m_rt[1], m_rt[0]} ||
          cfg_wr_tim !== {m_wt[1], m_wt[0]}) begin
         n_bad++;
         $display("FAIL %s: actual rdata=%h open=%b ctrl=%h misc=%h rt=%h wt=%h expected rdata=%h open=%b ctrl=%h misc=%h rt=%h wt=%h",
                  tag, bus_rdata, win_open, cfg_ctrl, cfg_misc, cfg_rd_tim, cfg_wr_tim,
                  e_rd, m_open, m_ctrl, m_misc, {m_rt[1], m_rt[0]}, {m_wt[1], m_wt[0]});
      end
      @(posedge clk);
      m_step(rd, wr, wd, a, d);
   endtask

   task automatic do_reset(logic s);
      @(negedge clk);
      rst = 1; strap_in = s; bus_rd = 0; bus_wr = 0;
      repeat (3) @(negedge clk);
      m_reset(s);
      rst = 0;
      strap_in = ~s;
   endtask

   // shorthands: word read, byte read, word write, byte write
   task automatic rw(logic [2:0] a, string t); cyc(1, 0, 1, a, 16'h0, t); endtask
   task automatic rb(logic [2:0] a, string t); cyc(1, 0, 0, a, 16'h0, t); endtask
   task automatic ww(logic [2:0] a, logic [15:0] d, string t); cyc(0, 1, 1, a, d, t); endtask
   task automatic wb(logic [2:0] a, logic [7:0] d, string t); cyc(0, 1, 0, a, {8'hA5, d}, t); endtask
   task automatic unlock(string t); rw(1, t); rw(1, t); wb(2, 8'h03, t); endtask

   initial begin
      do_reset(1'b1);
      cyc(0, 0, 0, 0, 0, "R1");
      for (int i = 0; i < 8; i++) rw(3'(i), "R1");

      ww(4, 16'hBEEF, "R2"); rw(4, "R2"); wb(4, 8'h12, "R2"); rw(4, "R2"); rb(4, "R2");
      ww(1, 16'h5A5A, "R2"); ww(0, 16'h1234, "R2"); rb(1, "R2");
      cyc(0, 0, 1, 4, 0, "R2");

      rw(1, "R4"); rw(1, "R4"); cyc(0, 1, 1, 2, 16'h0003, "R4"); rw(3, "R4");
      rw(1, "R4"); rw(0, "R4"); wb(2, 8'h03, "R4"); rw(6, "R4");
      rw(1, "R4"); rb(1, "R4"); wb(2, 8'h03, "R4"); rw(6, "R4");
      rw(1, "R4"); rw(1, "R4"); wb(2, 8'h04, "R4"); rw(6, "R4");
      rw(1, "R4"); wb(2, 8'h03, "R4"); rw(6, "R4");
      rw(1, "R4"); ww(5, 16'h7777, "R4"); rw(1, "R4"); wb(2, 8'h03, "R4"); rw(6, "R4");

      unlock("R3"); rw(6, "R3"); rw(3, "R3");

      wb(0, 8'h3A, "R6"); wb(1, 8'h4B, "R6"); wb(6, 8'h01, "R6");
      wb(0, 8'hC5, "R6"); ww(1, 16'hFF77, "R6"); rw(0, "R6"); rb(1, "R6");
      wb(6, 8'h00, "R6"); rw(0, "R6"); rw(1, "R11");

      wb(3, 8'h95, "R7"); rw(3, "R7"); wb(3, 8'h11, "R7"); wb(3, 8'h95, "R7"); rb(3, "R7");
      wb(5, 8'hFE, "R8"); rw(5, "R8"); ww(5, 16'hFFFF, "R8"); rb(5, "R8");
      wb(6, 8'hFF, "R9"); rw(6, "R9"); rw(0, "R9"); wb(6, 8'hAA, "R9"); rw(6, "R9");
      rw(2, "R10"); rw(4, "R10"); rw(7, "R10");
      ww(4, 16'h9999, "R10"); wb(7, 8'h66, "R10"); wb(2, 8'h55, "R10");

      ww(2, 16'h0083, "R5"); rw(3, "R5"); wb(2, 8'h84, "R5"); rw(3, "R5");
      wb(2, 8'h83, "R5"); rw(2, "R5"); rw(4, "R10"); rw(7, "R10"); rw(0, "R10");

      rw(1, "R3"); rw(1, "R3"); rw(1, "R3"); wb(2, 8'h03, "R3"); rw(0, "R11"); rw(6, "R11");
      wb(2, 8'h83, "R5"); rw(6, "R5");

      do_reset(1'b0);
      cyc(0, 0, 0, 0, 0, "R1"); rw(4, "R1");
      unlock("R8"); rw(5, "R8"); rw(3, "R1"); rw(0, "R1"); wb(2, 8'h83, "R5");
      rw(2, "R1");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog (all R): actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule